// File: doc/BRIEF.md
# Banked Scratchpad with Conflict Serialization

This block is an on-chip scratchpad that serves a whole 32-lane request in one transaction. A request is either all reads or all writes. Each lane carries its own word address, and an active mask says which lanes take part. The storage is split into 32 banks, each one 32-bit word wide. A word address selects its bank with its low five bits and its row with the bits above them.

Within one service cycle every bank serves one distinct word. Reading lanes that target that same word share one bank access and all receive the word. Active lanes that target different words of one bank are served over further cycles. The bank serves the pending lane with the lowest lane number first, together with every other lane that targets the same word. The number of service cycles is therefore the largest count of distinct words requested in any one bank. The block reports that count alongside the read data.

The request side is a valid/ready interface. A request is accepted on a rising clock edge where `req_valid` and `req_ready` are both high. The requester must hold `req_valid` and the payload steady until then. `req_ready` stays low from acceptance until the response cycle, so at most one request is in flight. The response is a one-cycle `rsp_valid` pulse with no back-pressure. The requester must be able to take the response in that cycle.

Top module: `sp_scratchpad`

## Requirements
- R1: A word at address A is stored in bank A mod 32 at row A div 32. A word written through any lane can be read back through any other lane at the same address.
- R2: Active read lanes that address the identical word need one service cycle together, and each of them receives that word.
- R3: `rsp_cycles` equals the maximum, over all banks, of the number of distinct active addresses mapping to that bank. `rsp_valid` rises exactly `rsp_cycles`+1 clock edges after the accepting edge.
- R4: With lane i addressing word i·s and all lanes active, `rsp_cycles` is 1 for s = 1, 3 and 33. It is 2 for s = 2, 4 for s = 4 and 32 for s = 32.
- R5: When several active lanes write the same word, the word afterwards holds the data of the highest-numbered of those lanes.
- R6: Inactive lanes are not accessed and return 0 in `rsp_rdata`. A write request returns 0 on all lanes. A request with an all-zero mask completes with `rsp_cycles` = 0 and `rsp_valid` one edge after acceptance.
- R7: `req_ready` is low from the accepting edge until the cycle in which `rsp_valid` is high. A request offered while `req_ready` is low has no effect on the storage.
- R8: `rsp_valid` is high for exactly one cycle per request. `rsp_rdata` and `rsp_cycles` keep their values after that pulse until the next request is accepted.
- R9: During and after reset, `req_ready` is 1 and `rsp_valid` is 0. `rsp_cycles` and `rsp_rdata` read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | The block can accept a request |
| req_write | input | 1 | 1: all active lanes write, 0: all active lanes read |
| req_mask | input | 32 | Active lane mask, bit i for lane i |
| req_addr | input | 320 | Lane i word address in bits [10i+9:10i] |
| req_wdata | input | 1024 | Lane i write data in bits [32i+31:32i] |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 1024 | Lane i read data in bits [32i+31:32i] |
| rsp_cycles | output | 6 | Service cycles spent on the last request |

## Verification
A lane dropped from its pending set too early would return a stale or zero word in `rsp_rdata` at the completion pulse. A lane that is never cleared keeps `req_ready` low and stops `rsp_valid` from arriving at `rsp_cycles`+1 edges. Both show up within the request that caused them. A wrong grouping of lanes by bank or word changes the pulse timing in the same request. It also corrupts written data, which surfaces when the word is next read. A faulty conflict count differs from the observed latency at once. Comparing ready and valid against a model on every clock catches an early or late pulse on the exact cycle it happens.

// File: rtl/sp_pkg.sv
`timescale 1ns/1ps
package sp_pkg;
  parameter int SP_LANES  = 32;
  parameter int SP_BANKS  = 32;
  parameter int SP_ROWS   = 32;
  parameter int SP_WORD_W = 32;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SERVE = 2'd1,
    ST_DRAIN = 2'd2
  } sp_state_e;
endpackage

// File: rtl/sp_conflict_count.sv
`timescale 1ns/1ps
// Worst-case number of distinct words falling into any single bank.
module sp_conflict_count #(
  parameter int LANES = 32,
  parameter int BANKS = 32,
  parameter int AW    = 10,
  parameter int CNT_W = 6
) (
  input  logic [LANES-1:0]    mask,
  input  logic [LANES*AW-1:0] addr,
  output logic [CNT_W-1:0]    worst
);
  localparam int BANK_W = $clog2(BANKS);

  logic [LANES-1:0] first_of_word;

  // A lane is the first of its word when no lower active lane has the same address.
  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      first_of_word[l] = mask[l];
      for (int j = 0; j < l; j++) begin
        if (mask[j] && (addr[j*AW +: AW] == addr[l*AW +: AW]))
          first_of_word[l] = 1'b0;
      end
    end
  end

  always_comb begin
    int best;
    int cnt;
    best = 0;
    for (int b = 0; b < BANKS; b++) begin
      cnt = 0;
      for (int l = 0; l < LANES; l++) begin
        if (first_of_word[l] && (addr[l*AW +: BANK_W] == BANK_W'(b)))
          cnt = cnt + 1;
      end
      if (cnt > best) best = cnt;
    end
    worst = CNT_W'(best);
  end
endmodule

// File: rtl/sp_bank_arbiter.sv
`timescale 1ns/1ps
// Per-bank pick: lowest pending lane leads, all lanes on its word join it.
module sp_bank_arbiter #(
  parameter int LANES   = 32,
  parameter int AW      = 10,
  parameter int BANK_W  = 5,
  parameter int WORD_W  = 32,
  parameter int BANK_ID = 0
) (
  input  logic [LANES-1:0]        pend,
  input  logic [LANES*AW-1:0]     addr,
  input  logic [LANES*WORD_W-1:0] wdata,
  output logic [LANES-1:0]        grp,
  output logic                    en,
  output logic [AW-BANK_W-1:0]    row,
  output logic [WORD_W-1:0]       wword
);
  logic [LANES-1:0] cand;
  logic [AW-1:0]    lead;
  logic             found;

  always_comb begin
    for (int l = 0; l < LANES; l++)
      cand[l] = pend[l] && (addr[l*AW +: BANK_W] == BANK_W'(BANK_ID));
  end

  always_comb begin
    found = 1'b0;
    lead  = '0;
    for (int l = 0; l < LANES; l++) begin
      if (cand[l] && !found) begin
        found = 1'b1;
        lead  = addr[l*AW +: AW];
      end
    end
  end

  always_comb begin
    wword = '0;
    for (int l = 0; l < LANES; l++) begin
      grp[l] = cand[l] && (addr[l*AW +: AW] == lead);
      if (grp[l]) wword = wdata[l*WORD_W +: WORD_W];  // later (higher) lane overrides
    end
  end

  assign en  = found;
  assign row = lead[AW-1:BANK_W];
endmodule

// File: rtl/sp_bank.sv
`timescale 1ns/1ps
// One bank: single port, registered read.
module sp_bank #(
  parameter int ROWS   = 32,
  parameter int ROW_W  = 5,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              we,
  input  logic [ROW_W-1:0]  row,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] store [ROWS];

  always_ff @(posedge clk) begin
    if (en && we) store[row] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rdata <= '0;
    else if (en && !we)  rdata <= store[row];
  end
endmodule

// File: rtl/sp_scratchpad.sv
`timescale 1ns/1ps
module sp_scratchpad
  import sp_pkg::*;
#(
  parameter int LANES  = SP_LANES,
  parameter int BANKS  = SP_BANKS,
  parameter int ROWS   = SP_ROWS,
  parameter int WORD_W = SP_WORD_W,
  parameter int AW     = $clog2(BANKS*ROWS),
  parameter int CNT_W  = $clog2(LANES+1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_write,
  input  logic [LANES-1:0]        req_mask,
  input  logic [LANES*AW-1:0]     req_addr,
  input  logic [LANES*WORD_W-1:0] req_wdata,
  output logic                    rsp_valid,
  output logic [LANES*WORD_W-1:0] rsp_rdata,
  output logic [CNT_W-1:0]        rsp_cycles
);
  localparam int BANK_W = $clog2(BANKS);
  localparam int ROW_W  = AW - BANK_W;

  sp_state_e                 state;
  logic [LANES-1:0]          pend_q;
  logic                      write_q;
  logic [LANES*AW-1:0]       addr_q;
  logic [LANES*WORD_W-1:0]   wdata_q;
  logic [CNT_W-1:0]          cyc_q;
  logic [LANES-1:0]          sv_q;
  logic [LANES*WORD_W-1:0]   rdata_q;
  logic                      rsp_q;
  logic [CNT_W-1:0]          worst;
  logic [CNT_W-1:0]          svc_cnt;

  logic [LANES-1:0]  grp_b   [BANKS];
  logic              en_b    [BANKS];
  logic [ROW_W-1:0]  row_b   [BANKS];
  logic [WORD_W-1:0] wword_b [BANKS];
  logic [WORD_W-1:0] rd_b    [BANKS];
  logic [LANES-1:0]  served;
  logic [LANES-1:0]  pend_nx;
  logic              accept;
  logic              serving;

  assign req_ready  = (state == ST_IDLE);
  assign accept     = req_valid && req_ready;
  assign serving    = (state == ST_SERVE);
  assign rsp_valid  = rsp_q;
  assign rsp_rdata  = rdata_q;
  assign rsp_cycles = cyc_q;

  sp_conflict_count #(
    .LANES(LANES), .BANKS(BANKS), .AW(AW), .CNT_W(CNT_W)
  ) u_count (
    .mask (req_mask),
    .addr (req_addr),
    .worst(worst)
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    sp_bank_arbiter #(
      .LANES(LANES), .AW(AW), .BANK_W(BANK_W), .WORD_W(WORD_W), .BANK_ID(b)
    ) u_arb (
      .pend (pend_q),
      .addr (addr_q),
      .wdata(wdata_q),
      .grp  (grp_b[b]),
      .en   (en_b[b]),
      .row  (row_b[b]),
      .wword(wword_b[b])
    );

    sp_bank #(
      .ROWS(ROWS), .ROW_W(ROW_W), .WORD_W(WORD_W)
    ) u_bank (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (en_b[b] && serving),
      .we   (write_q),
      .row  (row_b[b]),
      .wdata(wword_b[b]),
      .rdata(rd_b[b])
    );
  end

  always_comb begin
    served = '0;
    for (int b = 0; b < BANKS; b++) served = served | grp_b[b];
    pend_nx = pend_q & ~served;
  end

  // Control and request capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      pend_q  <= '0;
      write_q <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      cyc_q   <= '0;
      rsp_q   <= 1'b0;
      svc_cnt <= '0;
    end else begin
      rsp_q <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            pend_q  <= req_mask;
            write_q <= req_write;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            cyc_q   <= worst;
            svc_cnt <= '0;
            state   <= (req_mask == '0) ? ST_DRAIN : ST_SERVE;
          end
        end
        ST_SERVE: begin
          pend_q  <= pend_nx;
          svc_cnt <= svc_cnt + CNT_W'(1);
          if (pend_nx == '0) state <= ST_DRAIN;
        end
        ST_DRAIN: begin
          state <= ST_IDLE;
          rsp_q <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Read return: bank output is one cycle behind the access
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sv_q    <= '0;
      rdata_q <= '0;
    end else begin
      sv_q <= (serving && !write_q) ? served : '0;
      if (accept) begin
        rdata_q <= '0;
      end else begin
        for (int l = 0; l < LANES; l++) begin
          if (sv_q[l])
            rdata_q[l*WORD_W +: WORD_W] <= rd_b[addr_q[l*AW +: BANK_W]];
        end
      end
    end
  end

  // R3: the number of service cycles spent matches the predicted conflict count
  a_r3_cycles_match: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DRAIN) |-> (svc_cnt == cyc_q));

  // R3: every service cycle retires at least one lane
  a_r3_progress: assert property (@(posedge clk) disable iff (!rst_n)
    serving |-> (served != '0));

  // R3: serving never adds pending lanes
  a_r3_no_new_pending: assert property (@(posedge clk) disable iff (!rst_n)
    serving |=> ((pend_q & ~$past(pend_q)) == '0));

  // R7: the captured request stays frozen while not ready
  a_r7_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> ($stable(addr_q) && $stable(write_q) && $stable(wdata_q)));

  // R8: completion is a single-cycle pulse
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

// File: tb/sp_scratchpad_tb.sv
`timescale 1ns/1ps
module sp_scratchpad_tb_top;
  localparam int LANES = 32;
  localparam int AW    = 10;
  localparam int W     = 32;
  localparam int NW    = 1024;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                req_valid = 1'b0;
  logic                req_ready;
  logic                req_write = 1'b0;
  logic [LANES-1:0]    req_mask = '0;
  logic [LANES*AW-1:0] req_addr = '0;
  logic [LANES*W-1:0]  req_wdata = '0;
  logic                rsp_valid;
  logic [LANES*W-1:0]  rsp_rdata;
  logic [5:0]          rsp_cycles;

  always #2.5 clk = ~clk;

  sp_scratchpad dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_mask(req_mask), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_cycles(rsp_cycles)
  );

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;
  logic [W-1:0]  mem_m [NW];
  logic [AW-1:0] ta [LANES];
  logic [W-1:0]  td [LANES];

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] fill(int a);
    return 32'h5A00_0000 + W'(a) * 32'h0001_0203;
  endfunction

  function automatic int model_cycles(logic [LANES-1:0] m);
    int best = 0;
    for (int b = 0; b < 32; b++) begin
      int q[$];
      for (int l = 0; l < LANES; l++) begin
        if (m[l] && (int'(ta[l]) % 32 == b)) begin
          bit seen = 0;
          foreach (q[i]) if (q[i] == int'(ta[l])) seen = 1;
          if (!seen) q.push_back(int'(ta[l]));
        end
      end
      if (q.size() > best) best = q.size();
    end
    return best;
  endfunction

  task automatic set_stride(int s, int base);
    for (int l = 0; l < LANES; l++) ta[l] = AW'((base + l * s) % NW);
  endtask

  // One request; ready/valid compared against the model on every clock.
  task automatic run(bit wr, logic [LANES-1:0] m, bit intrude, string tag, int exp_n);
    int n;
    logic [W-1:0] exp_rd [LANES];
    logic [LANES*W-1:0] snap;
    n = model_cycles(m);
    if (exp_n >= 0) check({tag, " model cycle count"}, n, exp_n);
    for (int l = 0; l < LANES; l++)
      exp_rd[l] = (!wr && m[l]) ? mem_m[ta[l]] : '0;
    @(negedge clk);
    check("R7 ready before request", req_ready, 1);
    req_valid = 1'b1;
    req_write = wr;
    req_mask  = m;
    for (int l = 0; l < LANES; l++) begin
      req_addr[l*AW +: AW] = ta[l];
      req_wdata[l*W +: W]  = td[l];
    end
    @(negedge clk);
    req_valid = 1'b0;
    if (wr) for (int l = 0; l < LANES; l++) if (m[l]) mem_m[ta[l]] = td[l];
    for (int k = 1; k <= n + 2; k++) begin
      if (k > 1) @(negedge clk);
      if (intrude && k == 1) begin
        req_valid = 1'b1;
        req_write = 1'b1;
        req_mask  = 32'h1;
        req_addr[AW-1:0] = 10'h3FF;
        req_wdata[W-1:0] = 32'hDEAD_BEEF;
      end
      if (intrude && k == 2) req_valid = 1'b0;
      check("R7 ready low while busy", req_ready, (k == n + 2) ? 1 : 0);
      check({tag, " R3 completion timing"}, rsp_valid, (k == n + 2) ? 1 : 0);
    end
    check({tag, " R3 rsp_cycles"}, rsp_cycles, n);
    for (int l = 0; l < LANES; l++)
      check({tag, " R6 lane read data"}, rsp_rdata[l*W +: W], exp_rd[l]);
    snap = rsp_rdata;
    @(negedge clk);
    check("R8 pulse ends", rsp_valid, 0);
    check("R8 data held", (rsp_rdata == snap) ? 1 : 0, 1);
    check("R8 count held", rsp_cycles, n);
  endtask

  initial begin
    #(200000 * 5);
    if (!done_flag) begin
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int l = 0; l < LANES; l++) begin ta[l] = '0; td[l] = '0; end
    repeat (3) @(negedge clk);
    check("R9 ready in reset", req_ready, 1);
    check("R9 valid in reset", rsp_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 ready after reset", req_ready, 1);
    check("R9 valid after reset", rsp_valid, 0);
    check("R9 cycles after reset", rsp_cycles, 0);
    check("R9 rdata after reset", (rsp_rdata == '0) ? 1 : 0, 1);

    // R1: fill every word, one row per request
    for (int r = 0; r < 32; r++) begin
      for (int l = 0; l < LANES; l++) begin
        ta[l] = AW'(r * 32 + l);
        td[l] = fill(r * 32 + l);
      end
      run(1'b1, '1, 1'b0, "R1 fill", 1);
    end

    // R1/R4: stride patterns, read back across lanes
    set_stride(1, 0);   run(1'b0, '1, 1'b0, "R4 stride1 R1", 1);
    set_stride(2, 0);   run(1'b0, '1, 1'b0, "R4 stride2", 2);
    set_stride(3, 5);   run(1'b0, '1, 1'b0, "R4 stride3", 1);
    set_stride(4, 0);   run(1'b0, '1, 1'b0, "R4 stride4", 4);
    set_stride(32, 7);  run(1'b0, '1, 1'b0, "R4 stride32", 32);
    set_stride(33, 0);  run(1'b0, '1, 1'b0, "R4 stride33", 1);
    set_stride(1, 500); run(1'b0, '1, 1'b0, "R1 offset lanes", -1);

    // R2: broadcast of one word to all lanes
    for (int l = 0; l < LANES; l++) ta[l] = 10'd77;
    run(1'b0, '1, 1'b0, "R2 broadcast", 1);

    // R3/R6: partial mask, mixed shared and conflicting words
    for (int l = 0; l < LANES; l++) ta[l] = AW'((l * 37 + (l / 4) * 64) % NW);
    ta[5] = ta[4];
    run(1'b0, 32'h0F0F_00F3, 1'b0, "R3 R6 mixed", -1);

    // R5: same-word writes, highest lane wins; plus a two-word bank conflict
    for (int l = 0; l < LANES; l++) begin ta[l] = 10'd200; td[l] = 32'hC000_0000 + W'(l); end
    ta[0] = 10'd5; ta[1] = 10'd37;
    run(1'b1, 32'h0010_020B, 1'b0, "R5 write", 2);
    for (int l = 0; l < LANES; l++) ta[l] = 10'd200;
    ta[30] = 10'd5; ta[31] = 10'd37;
    run(1'b0, '1, 1'b0, "R5 readback", 2);
    check("R5 winner lane 20", mem_m[200], 32'hC000_0014);

    // R6: empty masks
    set_stride(1, 0);
    run(1'b0, '0, 1'b0, "R6 empty read", 0);
    run(1'b1, '0, 1'b0, "R6 empty write", 0);
    run(1'b0, 32'hFFFF_FFFF, 1'b0, "R6 unchanged after empty write", 1);

    // R7: request offered while busy is ignored
    set_stride(2, 0);
    run(1'b0, '1, 1'b1, "R7 busy", 2);
    for (int l = 0; l < LANES; l++) ta[l] = 10'h3FF;
    run(1'b0, '1, 1'b0, "R7 ignored write", 1);
    check("R7 word 1023 kept", rsp_rdata[W-1:0], fill(1023));

    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule